// File: doc/BRIEF.md
# Comparator Offset Trim Sweep Controller

This block trims the input offset of one latched comparator before conversions begin. Each comparator gets its own instance. A calibration run starts with a one-cycle start pulse. The block then drives a 6-bit code into an external current-steering trim DAC and raises that code by one on every clock. Each step moves the comparator's bias a little further in one fixed direction.

The block watches the comparator decision bit on every clock. As soon as the decision differs from the one seen on the clock before, the bias has crossed the balance point. The code is then frozen and kept for every later conversion. The trim is held as a digital word, not as charge on a capacitor, so it never needs a refresh cycle. If the sweep reaches the top code without any crossing, the block stops there and reports saturation.

Top module: `ofs_trim_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the trim code is 0 and both the done flag and the saturation flag are 0.
- R2: A start pulse clears the trim code to 0 and clears both flags on the next clock. This holds from any state, including in the middle of a sweep and after done.
- R3: On the first clock after start, the decision bit is only stored as the reference. The code stays 0 and done stays 0 on that clock, whatever the decision value is.
- R4: On each later sweep clock where the decision equals the decision stored on the previous clock, the trim code rises by exactly 1.
- R5: When the decision differs from the previous one, the code keeps its present value and done rises on that clock edge, with the saturation flag at 0. This includes a change on the very first compare, which leaves the code at 0.
- R6: Once done is 1, the code and the flags hold their values regardless of the decision bit, until the next start or reset.
- R7: If the code is 63 (all ones) and the decision still has not changed, the code stays at 63 and done and the saturation flag both rise together. The code never wraps around.
- R8: Before any start after reset, the decision bit is ignored: the code stays 0 and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Calibration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_start | input | 1 | One-cycle pulse that begins a new sweep |
| cmp_dec | input | 1 | Decision bit from the comparator |
| trim_code | output | 6 | Code sent to the trim DAC |
| cal_done | output | 1 | High when the sweep has stopped (crossing found or saturated) |
| cal_sat | output | 1 | High when the sweep stopped at the top code without a crossing |

## Verification
The embedded assertions check these rules on every cycle:
- a start always leaves a cleared code and cleared flags;
- the code never moves by more than one step and never leaves all ones once it gets there;
- a detected polarity change raises done with the code frozen;
- a finished result stays stable.

Some behaviour only the bench scenarios can show, because it depends on the exact count of stable decisions fed in:
- the exact code where a crossing lands;
- the full walk up to saturation;
- a crossing on the very first compare;
- a restart in mid-sweep.

A cycle-accurate reference model in the bench covers these by comparing every output on every clock.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [1:0] {
        CAL_IDLE  = 2'd0,
        CAL_REF   = 2'd1,
        CAL_SWEEP = 2'd2,
        CAL_HOLD  = 2'd3
    } cal_state_e;

    typedef struct packed {
        cal_state_e st;
        logic       done;
        logic       sat;
    } cal_ctrl_t;
endpackage

// File: rtl/trim_counter.sv
module trim_counter #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [CODE_W-1:0] code_o,
    output logic              at_max_o
);
    localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (clr_i)
            code_d = '0;
        else if (inc_i)
            code_d = code_q + CODE_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_q <= '0;
        else
            code_q <= code_d;
    end

    assign code_o   = code_q;
    assign at_max_o = &code_q;

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + CODE_ONE));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max_o && !clr_i) |=> at_max_o);
endmodule

// File: rtl/polarity_det.sv
module polarity_det (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic flip_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (load_i)
            prev_d = dec_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= prev_d;
    end

    assign flip_o = dec_i ^ prev_q;
endmodule

// File: rtl/ofs_trim_ctrl.sv
module ofs_trim_ctrl #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              cmp_dec,
    output logic [CODE_W-1:0] trim_code,
    output logic              cal_done,
    output logic              cal_sat
);
    import cal_pkg::*;

    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

    cal_ctrl_t ctl_d, ctl_q;
    logic      clr, inc, load;
    logic      flip, at_max;

    polarity_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .dec_i  (cmp_dec),
        .flip_o (flip)
    );

    trim_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .inc_i    (inc),
        .code_o   (trim_code),
        .at_max_o (at_max)
    );

    always_comb begin
        ctl_d = ctl_q;
        clr   = 1'b0;
        inc   = 1'b0;
        load  = 1'b0;
        if (cal_start) begin
            ctl_d.st   = CAL_REF;
            ctl_d.done = 1'b0;
            ctl_d.sat  = 1'b0;
            clr        = 1'b1;
        end else begin
            unique case (ctl_q.st)
                CAL_REF: begin
                    load     = 1'b1;
                    ctl_d.st = CAL_SWEEP;
                end
                CAL_SWEEP: begin
                    load = 1'b1;
                    if (flip) begin
                        ctl_d.st   = CAL_HOLD;
                        ctl_d.done = 1'b1;
                    end else if (at_max) begin
                        ctl_d.st   = CAL_HOLD;
                        ctl_d.done = 1'b1;
                        ctl_d.sat  = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '{st: CAL_IDLE, done: 1'b0, sat: 1'b0};
        else
            ctl_q <= ctl_d;
    end

    assign cal_done = ctl_q.done;
    assign cal_sat  = ctl_q.sat;

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> (trim_code == '0) && !cal_done && !cal_sat);

    // R3
    ref_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == CAL_REF && !cal_start) |=> (trim_code == '0) && !cal_done);

    // R5
    cross_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == CAL_SWEEP && flip && !cal_start) |=> cal_done && !cal_sat && $stable(trim_code));

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_start) |=> cal_done && $stable(trim_code) && $stable(cal_sat));

    // R7
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_sat |-> cal_done && (trim_code == CODE_TOP));
endmodule

// File: tb/ofs_trim_ctrl_bench.sv
module ofs_trim_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic       cmp_dec = 1'b0;
    logic [5:0] trim_code;
    logic       cal_done, cal_sat;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 reference, 2 sweeping, 3 stopped
    int m_phase = 0;
    int m_code  = 0;
    int m_done  = 0;
    int m_sat   = 0;
    int m_prev  = 0;

    always #2.5 clk = ~clk;

    ofs_trim_ctrl u_ofs_trim_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .cmp_dec   (cmp_dec),
        .trim_code (trim_code),
        .cal_done  (cal_done),
        .cal_sat   (cal_sat)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 0; m_code <= 0; m_done <= 0; m_sat <= 0; m_prev <= 0;
        end else if (cal_start) begin
            m_phase <= 1; m_code <= 0; m_done <= 0; m_sat <= 0;
        end else if (m_phase == 1) begin
            m_prev <= int'(cmp_dec); m_phase <= 2;
        end else if (m_phase == 2) begin
            if (int'(cmp_dec) != m_prev) begin
                m_done <= 1; m_phase <= 3;
            end else if (m_code == 63) begin
                m_done <= 1; m_sat <= 1; m_phase <= 3;
            end else begin
                m_code <= m_code + 1; m_prev <= int'(cmp_dec);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        chk(cur_req, "trim_code", int'(trim_code), m_code);
        chk(cur_req, "cal_done", int'(cal_done), m_done);
        chk(cur_req, "cal_sat", int'(cal_sat), m_sat);
    endtask

    task automatic cyc(input logic s, input logic d);
        @(negedge clk);
        cal_start = s;
        cmp_dec   = d;
        @(posedge clk);
        #1;
        cycles++;
        compare_model();
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "code in reset", int'(trim_code), 0);
        chk("R1", "done in reset", int'(cal_done), 0);
        rst_n = 1'b1;
        cyc(0, 0);

        // R8 decisions ignored before start
        cur_req = "R8";
        for (int i = 0; i < 6; i++) cyc(0, logic'(i % 2));
        chk("R8", "idle code", int'(trim_code), 0);

        // R2 R3 R4 R5: crossing after nine stable decisions
        cur_req = "R3";
        cyc(1, 0);
        cyc(0, 1);
        chk("R3", "code after reference", int'(trim_code), 0);
        cur_req = "R4";
        for (int i = 0; i < 9; i++) cyc(0, 1);
        chk("R4", "code after nine steps", int'(trim_code), 9);
        cur_req = "R5";
        cyc(0, 0);
        chk("R5", "frozen code", int'(trim_code), 9);
        chk("R5", "done on crossing", int'(cal_done), 1);
        chk("R5", "no sat on crossing", int'(cal_sat), 0);

        // R6 hold against toggling decisions
        cur_req = "R6";
        for (int i = 0; i < 8; i++) cyc(0, logic'(i % 2));
        chk("R6", "held code", int'(trim_code), 9);

        // R2 restart from hold
        cur_req = "R2";
        cyc(1, 1);
        chk("R2", "cleared code", int'(trim_code), 0);
        chk("R2", "cleared done", int'(cal_done), 0);

        // R5 boundary: change on first compare
        cur_req = "R5";
        cyc(0, 1);
        cyc(0, 0);
        chk("R5", "first-compare code", int'(trim_code), 0);
        chk("R5", "first-compare done", int'(cal_done), 1);

        // R2 restart in mid-sweep
        cur_req = "R2";
        cyc(1, 0);
        cyc(0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0);
        chk("R2", "mid-sweep code", int'(trim_code), 5);
        cyc(1, 0);
        chk("R2", "mid-sweep restart", int'(trim_code), 0);

        // R7 saturation
        cur_req = "R7";
        cyc(0, 0);
        for (int i = 0; i < 63; i++) cyc(0, 0);
        chk("R7", "top code reached", int'(trim_code), 63);
        chk("R7", "not yet done", int'(cal_done), 0);
        cyc(0, 0);
        chk("R7", "sat flag", int'(cal_sat), 1);
        chk("R7", "done with sat", int'(cal_done), 1);
        for (int i = 0; i < 4; i++) cyc(0, logic'(i % 2));
        chk("R7", "no wrap", int'(trim_code), 63);

        // R1 reset from hold
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "code after reset", int'(trim_code), 0);
        chk("R1", "sat after reset", int'(cal_sat), 0);
        rst_n = 1'b1;
        cyc(0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule